// File: doc/BRIEF.md
# Glitch-Free Selectable Card Clock Divider

This block derives the clock sent to a smart card from a reference clock. A 2-bit select picks a ratio of 1, 2, 4 or 8, and an enable from the power sequencer decides whether the card sees a clock at all. The divided ratios come from a registered output, so their high and low phases are equal. The ratio of 1 gates the reference clock straight through.

Both the select and the enable pass through a synchroniser. A free-running 3-bit counter splits time into frames of eight reference cycles, counted from reset release. A new ratio or enable state is adopted only at a frame boundary. At that point every divided clock is low, so the output never carries a pulse that was cut short. The gate for the pass-through path changes only on the falling edge of the reference clock. This keeps the first and last pass-through pulses whole.

Top module: `card_clk_divider`

## Requirements
- R1: The select code sets the ratio: 2'b00 divides by 8, 2'b01 divides by 4, 2'b11 divides by 2, 2'b10 passes the reference clock through (ratio 1).
- R2: When enabled at ratio 2, 4 or 8, the output is a register that is low for the first half of each output period and high for the second half. The period is measured from a frame boundary, and the two halves are equal in length: one, two or four reference cycles.
- R3: When enabled at ratio 1, the output equals the reference clock, starting from the first rising reference edge after the frame boundary at which the ratio was adopted.
- R4: The select and the enable each pass through a 2-stage synchroniser. Their synchronised values are adopted only at the rising edge that ends an 8-cycle frame, counted from reset release. A change therefore reaches the output within 10 reference cycles.
- R5: A ratio change never produces a high or low pulse shorter than half a reference period. Divided outputs never rise at a frame start.
- R6: While disabled, the output is low. Disabling takes effect only at a frame boundary, and the pass-through gate closes only while the reference clock is low.
- R7: During reset, the output is low, the adopted ratio is 8 and the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 2 | Ratio select code (see R1) |
| clk_en | input | 1 | Enable from the power sequencer |
| card_clk | output | 1 | Clock driven to the card |

## Verification
A behavioural model tracks the frame phase, the two-cycle select delay and the adopted ratio. It predicts the output in both halves of every reference cycle, and the bench compares the design against it. The bench first holds each of the four select codes long enough to settle. This separates the encoding from the duty pattern. It then switches between every pair of ratios, including both directions between pass-through and divide-by-8. These switches expose any truncated pulse at the handover, or a switch that lands at the wrong frame boundary. The enable is toggled in pass-through mode, where a badly timed gate shows up as a half pulse. A select pulse of a single cycle and a count of output edges over a fixed window confirm the latency and the duty.

// File: rtl/card_clk_divider.sv
module card_clk_divider #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_in,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       clk_en,
  output logic       card_clk
);
  localparam int CNT_W = 3;
  localparam logic [1:0] SEL_D8 = 2'b00;
  localparam logic [1:0] SEL_D4 = 2'b01;
  localparam logic [1:0] SEL_D2 = 2'b11;
  localparam logic [1:0] SEL_D1 = 2'b10;

  logic [SYNC_STAGES-1:0] sync_hi, sync_lo, sync_en;
  logic [1:0]       sel_s, mode_q, mode_nx;
  logic             en_s, act_q, act_nx, out_q, gate_q, wrap;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      sync_hi <= '0;
      sync_lo <= '0;
      sync_en <= '0;
    end else begin
      sync_hi <= {sync_hi[SYNC_STAGES-2:0], div_sel[1]};
      sync_lo <= {sync_lo[SYNC_STAGES-2:0], div_sel[0]};
      sync_en <= {sync_en[SYNC_STAGES-2:0], clk_en};
    end
  end

  assign sel_s   = {sync_hi[SYNC_STAGES-1], sync_lo[SYNC_STAGES-1]};
  assign en_s    = sync_en[SYNC_STAGES-1];
  assign wrap    = &cnt;
  assign cnt_nx  = cnt + 1'b1;
  assign mode_nx = wrap ? sel_s : mode_q;
  assign act_nx  = wrap ? en_s : act_q;

  function automatic logic pick(input logic [1:0] m, input logic [CNT_W-1:0] c);
    case (m)
      SEL_D2:  pick = c[0];
      SEL_D4:  pick = c[1];
      SEL_D8:  pick = c[2];
      default: pick = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= SEL_D8;
      act_q  <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      mode_q <= mode_nx;
      act_q  <= act_nx;
      out_q  <= act_nx & pick(mode_nx, cnt_nx);
    end
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= act_q & (mode_q == SEL_D1);
  end

  assign card_clk = out_q | (clk_in & gate_q);
endmodule

// File: rtl/card_clk_divider_chk.sv
module card_clk_divider_chk (
  input logic       clk_in,
  input logic       rst_n,
  input logic [1:0] sel_s,
  input logic [1:0] mode_q,
  input logic [2:0] cnt,
  input logic       act_q,
  input logic       out_q,
  input logic       gate_q
);
  p_switch_at_frame_end_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> ($past(cnt) == 3'd7));

  p_adopts_synced_code_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (mode_q == $past(sel_s)));

  p_div2_toggles_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
    (act_q && mode_q == 2'b11 && $past(act_q && mode_q == 2'b11)) |-> (out_q != $past(out_q)));

  p_no_rise_at_frame_start_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(out_q) |-> (cnt != 3'd0));

  p_off_stays_low_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!act_q && !$past(act_q)) |-> (!out_q && !gate_q));
endmodule

bind card_clk_divider card_clk_divider_chk u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .sel_s(sel_s), .mode_q(mode_q),
  .cnt(cnt), .act_q(act_q), .out_q(out_q), .gate_q(gate_q)
);

// File: tb/tb_card_clk_divider.sv
module tb_card_clk_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic clk_en = 1'b0;
  logic card_clk;

  int n_chk = 0, n_fail = 0, rises = 0;
  bit done = 0;
  string tag = "R7";

  card_clk_divider dut (.clk_in(clk), .rst_n(rst_n), .div_sel(div_sel),
                        .clk_en(clk_en), .card_clk(card_clk));

  always #5 clk = ~clk;
  always @(posedge card_clk) rises++;

  // behavioural model state
  int ph = 0, cur_div = 8;
  bit cur_en = 0;
  logic [1:0] h1s = 0, h2s = 0;
  bit h1e = 0, h2e = 0;
  bit exp_hi, exp_lo;

  function automatic int ratio_of(logic [1:0] s);
    case (s)
      2'b00: return 8;
      2'b01: return 4;
      2'b11: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit act, input bit exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: card_clk=%b expected %b", tag, what, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; cur_div = 8; cur_en = 0; h1s = 0; h2s = 0; h1e = 0; h2e = 0;
      exp_hi = 0; exp_lo = 0;
    end else begin
      logic [1:0] use_s;
      bit use_e, g_old, wrap, dbit;
      use_s = h2s; use_e = h2e;
      h2s = h1s; h1s = div_sel; h2e = h1e; h1e = clk_en;
      g_old = cur_en && cur_div == 1;
      wrap = (ph == 7);
      ph = (ph + 1) % 8;
      if (wrap) begin
        cur_div = ratio_of(use_s);
        cur_en = use_e;
      end
      dbit = (cur_en && cur_div > 1) ? (((ph / (cur_div / 2)) % 2) == 1) : 1'b0;
      exp_hi = dbit | g_old;
      exp_lo = dbit;
    end
    #2 check(card_clk, exp_hi, "high phase");
    #5 check(card_clk, exp_lo, "low phase");
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #32 rst_n = 1'b1;                 // R7 checked while held low
    run(2);
    tag = "R6"; run(20);              // enable still low: output stays low
    clk_en = 1'b1;
    tag = "R1"; run(40);              // 00 -> /8
    tag = "R2"; div_sel = 2'b01; run(40);
    div_sel = 2'b11; run(40);
    tag = "R3"; div_sel = 2'b10; run(40);
    tag = "R5"; div_sel = 2'b00; run(30);
    div_sel = 2'b10; run(30);
    div_sel = 2'b11; run(30);
    div_sel = 2'b10; run(30);
    div_sel = 2'b01; run(30);
    tag = "R6"; div_sel = 2'b10; run(30);
    clk_en = 1'b0; run(30);
    clk_en = 1'b1; run(30);
    tag = "R4"; div_sel = 2'b00; run(1);
    div_sel = 2'b10; run(30);
    div_sel = 2'b11; run(3);
    div_sel = 2'b00; run(30);
    // R2: 64-cycle window at ratio 4 holds exactly 16 rising edges
    tag = "R2"; div_sel = 2'b01; run(30);
    rises = 0; run(64);
    n_chk++;
    if (rises != 16) begin
      n_fail++;
      $display("FAIL R2 edge count at /4: %0d expected 16", rises);
    end
    // R4: change visible no later than 10 cycles
    tag = "R4"; div_sel = 2'b11; run(10);
    rises = 0; run(16);
    n_chk++;
    if (rises != 8) begin
      n_fail++;
      $display("FAIL R4 /2 not in effect within 10 cycles: %0d edges expected 8", rises);
    end
    finish_run();
  end
endmodule